// File: doc/BRIEF.md
# Event-Number Mismatch Fragment Gate

This block sits inside an event builder that merges fragments arriving on several input channels. For every built event the builder holds a running event number. The gate compares the event number in each channel's fragment header with that number. It decides per channel whether the fragment goes into the built event. A configuration bit chooses the policy for a mismatching fragment: drop it and mark the channel as empty in the output header, or keep it and count the mismatch.

The gate also watches a trigger-rule violation flag inside each fragment's 16-bit error word. When reporting is enabled and any received fragment carries the flag, the link-status code moves to a sync-lost value. It stays there until the block is reset. A single `evt_valid` pulse presents all channel headers for one event. The decisions come out one cycle later, qualified by `out_valid`.

Top module: `evt_gate`

## Requirements
- R1: After reset `out_valid`, `keep` and `empty` are all zero, `link_status` is 8 (ready), every mismatch counter is zero, and the first event is built with event number 1.
- R2: A result appears exactly one clock after the cycle in which `evt_valid` is high, with `out_valid` high for that one cycle. `out_evn` carries the builder event number used for the comparison. `out_valid` is low on every other cycle.
- R3: A present channel whose fragment event number equals the builder number gets keep=1 and empty=0, and its mismatch counter is unchanged.
- R4: With `cfg_keep_mis`=0, a present channel whose fragment event number differs from the builder number gets keep=0 and empty=1, and its mismatch counter is unchanged.
- R5: With `cfg_keep_mis`=1, a present mismatching channel gets keep=1 and empty=0, and its 8-bit mismatch counter adds one. The counter saturates at 255.
- R6: A channel whose `ch_present` bit is 0 gets keep=0 and empty=1 whatever its event number field holds, and its counter is unchanged.
- R7: The builder event number rises by exactly one for every event, whether or not any fragment was dropped.
- R8: With `cfg_sync_rpt`=1, a present fragment whose error word has bit 3 (value 0x0008) set makes `link_status` equal 2 (sync-lost) in the result of that event. The same bit on an absent channel has no effect.
- R9: With `cfg_sync_rpt`=0, the violation bit has no effect on `link_status`.
- R10: Once `link_status` is 2 it stays 2 through all following events, whatever their contents, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | One-cycle strobe: headers for one event are present |
| ch_present | input | NUM_CH | Channel delivered a fragment for this event |
| ch_evn | input | NUM_CH*EVN_W | Fragment event numbers, channel 0 in the low bits |
| ch_err | input | NUM_CH*16 | Fragment error words, channel 0 in the low bits |
| cfg_keep_mis | input | 1 | 1: keep and count mismatching fragments; 0: drop them |
| cfg_sync_rpt | input | 1 | Enable sync-lost reporting on rule violations |
| out_valid | output | 1 | Result strobe |
| keep | output | NUM_CH | Per-channel keep decision |
| empty | output | NUM_CH | Per-channel no-data flag for the output header |
| out_evn | output | EVN_W | Builder event number of the result |
| link_status | output | 4 | 8 = ready, 2 = sync-lost |
| mism_cnt | output | NUM_CH*CNT_W | Per-channel saturating mismatch counters |

## Verification
The hardest condition to reach from the ports is counter saturation. The stimulus gets there with a long run of events in which one channel always carries the builder number plus one while keep-mode is on. It then checks that further mismatches leave the count at 255. Stickiness of sync-lost is the other hard case. After a violation has been flagged, the bench sends clean events with reporting disabled and confirms the code does not fall back. A second reset then shows that reset alone clears it.

// File: rtl/evt_gate_pkg.sv
package evt_gate_pkg;
  typedef enum logic [3:0] {
    LS_LOST  = 4'd2,
    LS_READY = 4'd8
  } link_st_e;

  localparam int ERR_W    = 16;
  localparam int RULE_BIT = 3;

  // violation flag of a received fragment
  function automatic logic rule_hit(input logic present, input logic [ERR_W-1:0] err);
    return present & err[RULE_BIT];
  endfunction

  // sticky status update
  function automatic link_st_e next_status(input link_st_e cur, input logic rpt_en,
                                           input logic any_viol);
    if (cur == LS_LOST) return LS_LOST;
    if (rpt_en && any_viol) return LS_LOST;
    return LS_READY;
  endfunction
endpackage

// File: rtl/evt_gate_evcnt.sv
module evt_gate_evcnt #(
  parameter int EVN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  output logic [EVN_W-1:0] evn_o
);
  localparam logic [EVN_W-1:0] FIRST_EVN = EVN_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)    evn_o <= FIRST_EVN;
    else if (fire) evn_o <= evn_o + EVN_W'(1);
  end

  p_evn_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (evn_o == $past(evn_o) + EVN_W'(1)));
  p_evn_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(evn_o));
endmodule

// File: rtl/evt_gate_chan.sv
module evt_gate_chan #(
  parameter int EVN_W = 24,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic             cfg_keep_mis,
  input  logic             present,
  input  logic [EVN_W-1:0] frag_evn,
  input  logic [EVN_W-1:0] bld_evn,
  output logic             keep_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic mism_seen;  // present fragment with a wrong event number
  logic take;       // fragment enters the built event
  assign mism_seen = present && (frag_evn != bld_evn);
  assign take      = present && (!mism_seen || cfg_keep_mis);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? v : v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keep_o  <= 1'b0;
      empty_o <= 1'b0;
      cnt_o   <= '0;
    end else if (fire) begin
      keep_o  <= take;
      empty_o <= !take;
      if (mism_seen && cfg_keep_mis) cnt_o <= sat_inc(cnt_o);
    end
  end

  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mism_seen && !cfg_keep_mis) |=> (empty_o && !keep_o && $stable(cnt_o)));
  p_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mism_seen && cfg_keep_mis) |=> (keep_o && (cnt_o != '0)));
  p_absent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !present) |=> (empty_o && $stable(cnt_o)));
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 (cnt_o >= $past(cnt_o)));
endmodule

// File: rtl/evt_gate_sync.sv
module evt_gate_sync
  import evt_gate_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fire,
  input  logic       cfg_sync_rpt,
  input  logic       any_viol,
  output logic [3:0] status_o
);
  link_st_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    st_q <= LS_READY;
    else if (fire) st_q <= next_status(st_q, cfg_sync_rpt, any_viol);
  end

  assign status_o = st_q;

  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == LS_LOST) |=> (status_o == LS_LOST));
  p_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && cfg_sync_rpt && any_viol) |=> (status_o == LS_LOST));
  p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !cfg_sync_rpt && status_o == LS_READY) |=> (status_o == LS_READY));
  p_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == LS_READY) || (status_o == LS_LOST));
endmodule

// File: rtl/evt_gate.sv
module evt_gate
  import evt_gate_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int EVN_W  = 24,
  parameter int CNT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    evt_valid,
  input  logic [NUM_CH-1:0]       ch_present,
  input  logic [NUM_CH*EVN_W-1:0] ch_evn,
  input  logic [NUM_CH*ERR_W-1:0] ch_err,
  input  logic                    cfg_keep_mis,
  input  logic                    cfg_sync_rpt,
  output logic                    out_valid,
  output logic [NUM_CH-1:0]       keep,
  output logic [NUM_CH-1:0]       empty,
  output logic [EVN_W-1:0]        out_evn,
  output logic [3:0]              link_status,
  output logic [NUM_CH*CNT_W-1:0] mism_cnt
);
  logic [EVN_W-1:0]  bld_evn;
  logic [NUM_CH-1:0] viol_vec;  // per-channel received rule violation
  logic              any_viol;

  evt_gate_evcnt #(.EVN_W(EVN_W)) u_evcnt (
    .clk(clk), .rst_n(rst_n), .fire(evt_valid), .evn_o(bld_evn)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign viol_vec[c] = rule_hit(ch_present[c], ch_err[c*ERR_W +: ERR_W]);

    evt_gate_chan #(.EVN_W(EVN_W), .CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .fire(evt_valid), .cfg_keep_mis(cfg_keep_mis),
      .present(ch_present[c]), .frag_evn(ch_evn[c*EVN_W +: EVN_W]),
      .bld_evn(bld_evn), .keep_o(keep[c]), .empty_o(empty[c]),
      .cnt_o(mism_cnt[c*CNT_W +: CNT_W])
    );
  end

  assign any_viol = |viol_vec;

  evt_gate_sync u_sync (
    .clk(clk), .rst_n(rst_n), .fire(evt_valid), .cfg_sync_rpt(cfg_sync_rpt),
    .any_viol(any_viol), .status_o(link_status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_evn   <= '0;
    end else begin
      out_valid <= evt_valid;
      if (evt_valid) out_evn <= bld_evn;
    end
  end

  p_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(evt_valid));
  p_header_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((keep ^ empty) == {NUM_CH{1'b1}}));
  p_evn_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> (out_evn == bld_evn - EVN_W'(1)));
endmodule

// File: tb/evt_gate_tb_top.sv
module evt_gate_tb_top;
  localparam int  NCH   = 4;
  localparam int  EW    = 24;
  localparam int  CW    = 8;
  localparam int  ERRW  = 16;
  localparam time CLK_T = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, evt_valid = 1'b0;
  logic [NCH-1:0] ch_present = '0;
  logic [NCH*EW-1:0] ch_evn = '0;
  logic [NCH*ERRW-1:0] ch_err = '0;
  logic cfg_keep_mis = 1'b0, cfg_sync_rpt = 1'b0;
  logic out_valid;
  logic [NCH-1:0] keep, empty;
  logic [EW-1:0] out_evn;
  logic [3:0] link_status;
  logic [NCH*CW-1:0] mism_cnt;

  evt_gate #(.NUM_CH(NCH), .EVN_W(EW), .CNT_W(CW)) dut_i (.*);

  always #(CLK_T/2) clk = ~clk;

  typedef struct {
    logic [NCH-1:0]    keep, empty;
    logic [EW-1:0]     evn;
    logic [3:0]        status;
    logic [NCH*CW-1:0] cnt;
  } exp_t;

  exp_t exp_q[$];
  int n_chk = 0, n_err = 0;
  int m_evn;
  int m_cnt[NCH];
  bit m_lost;

  task automatic chk(string req, logic [63:0] act, logic [63:0] expv, string what);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic model_reset();
    m_evn = 1; m_lost = 0;
    foreach (m_cnt[i]) m_cnt[i] = 0;
  endtask

  // drive one event: mism = channels carrying builder number + 1, viol = error bit 3 set
  task automatic send(logic [NCH-1:0] pres, logic [NCH-1:0] mism, logic [NCH-1:0] viol,
                      logic kcfg, logic scfg);
    exp_t e;
    @(negedge clk);
    evt_valid = 1'b1; ch_present = pres; cfg_keep_mis = kcfg; cfg_sync_rpt = scfg;
    for (int c = 0; c < NCH; c++) begin
      ch_evn[c*EW +: EW]     = EW'(m_evn + (mism[c] ? 1 : 0));
      ch_err[c*ERRW +: ERRW] = viol[c] ? 16'h8048 : 16'h8040;
    end
    e.evn = EW'(m_evn);
    for (int c = 0; c < NCH; c++) begin
      logic take;
      take = pres[c] && (!mism[c] || kcfg);
      e.keep[c] = take; e.empty[c] = !take;
      if (pres[c] && mism[c] && kcfg && m_cnt[c] < 255) m_cnt[c]++;
      e.cnt[c*CW +: CW] = CW'(m_cnt[c]);
    end
    if (scfg && |(pres & viol)) m_lost = 1;
    e.status = m_lost ? 4'd2 : 4'd8;
    m_evn++;
    exp_q.push_back(e);
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  // monitor: compare each result with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) chk("R2", 1, 0, "unexpected out_valid");
      else begin
        exp_t e;
        e = exp_q.pop_front();
        chk("R3", keep, e.keep, "keep");
        chk("R4", empty, e.empty, "empty");
        chk("R7", out_evn, e.evn, "out_evn");
        chk("R8", link_status, e.status, "link_status");
        chk("R5", mism_cnt, e.cnt, "mism_cnt");
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
    @(negedge clk);
    chk("R1", out_valid, 0, "out_valid after reset");
    chk("R1", keep, 0, "keep after reset");
    chk("R1", empty, 0, "empty after reset");
    chk("R1", link_status, 8, "status after reset");
    chk("R1", mism_cnt, 0, "counters after reset");
  endtask

  initial begin
    #(CLK_T*20000);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    send(4'hF, 4'h0, 4'h0, 0, 0);          // R3 all match, first number 1 (R1)
    send(4'hF, 4'h2, 4'h0, 0, 0);          // R4 ch1 dropped
    send(4'hF, 4'h4, 4'h0, 1, 0);          // R5 ch2 kept and counted
    send(4'h7, 4'h8, 4'h0, 0, 0);          // R6 ch3 absent with odd number
    send(4'h7, 4'h8, 4'h0, 1, 0);          // R6 absent mismatch not counted
    @(negedge clk);
    chk("R2", out_valid, 0, "idle cycle");
    send(4'hF, 4'h0, 4'h1, 0, 0);          // R9 violation without reporting
    chk("R9", link_status, 8, "status after unreported violation");
    send(4'h7, 4'h0, 4'h8, 0, 1);          // R8 violation on absent channel
    chk("R8", link_status, 8, "absent-channel violation ignored");
    send(4'hF, 4'h3, 4'h2, 1, 1);          // R8 reported violation
    chk("R8", link_status, 2, "sync-lost raised");
    for (int i = 0; i < 4; i++) send(4'hF, 4'h0, 4'h0, 0, 0);  // R10
    chk("R10", link_status, 2, "sync-lost held");
    for (int i = 0; i < 260; i++) send(4'h1, 4'h1, 4'h0, 1, 0); // R5 saturation
    chk("R5", mism_cnt[CW-1:0], 255, "ch0 saturated");
    @(negedge clk);
    chk("R2", exp_q.size(), 0, "all results seen");
    do_reset();                            // R1 and R10: reset clears sync-lost
    send(4'hF, 4'h0, 4'h0, 0, 0);
    @(negedge clk);
    chk("R1", out_evn, 1, "numbering restarts");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule